// File: doc/BRIEF.md
# Peripheral Reset and Clock-Stop Control Bank

This block holds the reset and clock-stop state for up to 64 peripherals in four 32-bit control words. It sits on a simple synchronous register bus that has an address, a write strobe, write data and combinational read data. Two words hold reset bits. Two words hold clock-stop bits.

Software never overwrites a whole word. Each word answers at two addresses:
- Writing ones at the word's base address sets those bits.
- Writing ones at base+4 clears those bits.
- Zero bits leave their bits unchanged at either address.

Reads at either address return the current word. Because writes only ever set or clear, agents that own different bits can update their own bits without a read-modify-write sequence.

The stored words drive two 64-bit output vectors:
- a per-peripheral reset vector;
- a per-peripheral clock-enable vector.

The clock-enable vector is the inverse of the stop bits, with one exception. Peripheral index 14 has the opposite sense: its bit set means its clock runs.

Top module: `setclr_ctrl_bank`

## Requirements
- R1: After reset, every reset bit is one (rstOut all ones) and every clock is stopped (clkEn all zero). The clock word at 0x080 therefore reads 0xFFFF_BFFF, with bit 14 zero. The other three words read 0xFFFF_FFFF.
- R2: A write at a word's base address (0x040, 0x050, 0x080, 0x090) ORs the written ones into that word. The new value is visible on the next cycle.
- R3: A write at base+4 (0x044, 0x054, 0x084, 0x094) clears every bit written as one.
- R4: Bits written as zero are unchanged at either alias. A write of all zeros changes nothing.
- R5: Peripheral index i maps to a word and bit as follows:
  - indices 0–31 are in the low word of a pair (0x040 for resets, 0x080 for clocks), and indices 32–63 are in the high word (0x050 and 0x090);
  - the bit position within the word is i mod 32.
- R6: clkEn[i] is the inverse of the stop bit for every index except 14. clkEn[14] equals its stop bit.
- R7: rstOut[i] equals the stored reset bit for index i, and that bit reads back at its word's address.
- R8: A read at the base address and a read at base+4 both return the current word. Reads have no side effects.
- R9: Writes to any address other than the eight mapped ones change no state. Reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address of the access |
| busWe | input | 1 | Write strobe for the current cycle |
| busWdata | input | 32 | Write data; ones select bits to set or clear |
| busRdata | output | 32 | Combinational read data for busAddr |
| rstOut | output | 64 | Per-peripheral reset, 1 = held in reset |
| clkEn | output | 64 | Per-peripheral clock enable, 1 = running |

## Verification
The embedded assertions check the following on every cycle:
- set and clear writes leave the written ones set or cleared;
- words not addressed by a write hold their value;
- the decoder never raises more than one word's read select, and raises no write strobe without a write;
- setting the inverted-polarity stop bit turns its enable on.

Some behaviour only the bench scenarios can show:
- the exact power-on values;
- the mapping of each of the 64 indices onto a word and bit, swept one bit at a time;
- that both aliases read back the same word;
- that writes to unmapped or unaligned addresses leave every word untouched and read as zero.

// File: rtl/setclr_pkg.sv
package setclr_pkg;
  // Word order: reset low, reset high, clock-stop low, clock-stop high
  localparam int NUM_WORDS = 4;
  localparam int RST_WORD0 = 0;
  localparam int CLK_WORD0 = 2;

  typedef struct packed {
    logic [NUM_WORDS-1:0] setHit;
    logic [NUM_WORDS-1:0] clrHit;
    logic [NUM_WORDS-1:0] rdHit;
  } bankStrobe_t;
endpackage

// File: rtl/setclr_decode.sv
module setclr_decode
  import setclr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int RST_LO_OFS = 'h040,
  parameter int RST_HI_OFS = 'h050,
  parameter int CLK_LO_OFS = 'h080,
  parameter int CLK_HI_OFS = 'h090,
  parameter int CLR_OFS    = 'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output bankStrobe_t       strb
);
  localparam logic [ADDR_W-1:0] BASE [NUM_WORDS] = '{
    ADDR_W'(RST_LO_OFS), ADDR_W'(RST_HI_OFS),
    ADDR_W'(CLK_LO_OFS), ADDR_W'(CLK_HI_OFS)};
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

  always_comb begin
    strb = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (busAddr == BASE[k]) begin
        strb.rdHit[k]  = 1'b1;
        strb.setHit[k] = busWe;
      end else if (busAddr == BASE[k] + CLR_A) begin
        strb.rdHit[k]  = 1'b1;
        strb.clrHit[k] = busWe;
      end
    end
  end

  // R8: at most one word is selected for read
  assert_single_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.rdHit));
  // R9: no write strobe ever reaches a word without a bus write
  assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|(strb.setHit | strb.clrHit)) |-> busWe);
  // R2/R3: a single access never both sets and clears
  assert_single_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.setHit | strb.clrHit));
endmodule

// File: rtl/setclr_regs.sv
module setclr_regs
  import setclr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INV_IDX = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  bankStrobe_t         strb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [2*DATA_W-1:0] rstOut,
  output logic [2*DATA_W-1:0] clkEn
);
  localparam int INV_WORD = CLK_WORD0 + INV_IDX / DATA_W;
  localparam int INV_BIT  = INV_IDX % DATA_W;
  localparam logic [2*DATA_W-1:0] INV_MASK = (2*DATA_W)'(1) << INV_IDX;

  logic [DATA_W-1:0] wordQ [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : gWord
    // Reset words start all ones; the inverted-polarity stop bit starts clear
    localparam logic [DATA_W-1:0] RST_VAL =
      (g == INV_WORD) ? ~(DATA_W'(1) << INV_BIT) : '1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                wordQ[g] <= RST_VAL;
      else if (strb.setHit[g])  wordQ[g] <= wordQ[g] | wrData;
      else if (strb.clrHit[g])  wordQ[g] <= wordQ[g] & ~wrData;
    end

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
      strb.setHit[g] |=> ((wordQ[g] & $past(wrData)) == $past(wrData)));
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
      strb.clrHit[g] |=> ((wordQ[g] & $past(wrData)) == '0));
    assert_hold_word_R4: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.setHit[g] || strb.clrHit[g]) |=> $stable(wordQ[g]));
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (strb.rdHit[k]) rdData = rdData | wordQ[k];
  end

  assign rstOut = {wordQ[RST_WORD0+1], wordQ[RST_WORD0]};
  assign clkEn  = ~{wordQ[CLK_WORD0+1], wordQ[CLK_WORD0]} ^ INV_MASK;

  // R6: setting the inverted stop bit runs that clock
  assert_inv_polarity_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setHit[INV_WORD] && wrData[INV_BIT]) |=> clkEn[INV_IDX]);
endmodule

// File: rtl/setclr_ctrl_bank.sv
module setclr_ctrl_bank #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int INV_IDX = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic [2*DATA_W-1:0] rstOut,
  output logic [2*DATA_W-1:0] clkEn
);
  setclr_pkg::bankStrobe_t strb;

  setclr_decode #(.ADDR_W(ADDR_W)) i_decode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .strb(strb));

  setclr_regs #(.DATA_W(DATA_W), .INV_IDX(INV_IDX)) i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWdata),
    .rdData(busRdata), .rstOut(rstOut), .clkEn(clkEn));
endmodule

// File: tb/test_setclr_ctrl_bank.sv
`timescale 1ns/1ps
module test_setclr_ctrl_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] rstOut, clkEn;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] model [4];
  int base [4] = '{'h040, 'h050, 'h080, 'h090};

  always #10 clk = ~clk;

  setclr_ctrl_bank i_setclr_ctrl_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .rstOut(rstOut), .clkEn(clkEn));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(int addr, logic [31:0] data);
    @(negedge clk);
    busAddr = 12'(addr); busWe = 1'b1; busWdata = data;
    @(negedge clk);
    busWe = 1'b0; busAddr = 12'h000; busWdata = '0;
  endtask

  task automatic busRead(int addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = 12'(addr); busWe = 1'b0;
    #2 data = busRdata;
  endtask

  function automatic logic [63:0] expClkEn();
    logic [63:0] e;
    for (int i = 0; i < 64; i++) begin
      logic stopBit;
      stopBit = model[2 + i / 32][i % 32];
      e[i] = (i == 14) ? stopBit : !stopBit;
    end
    return e;
  endfunction

  task automatic verifyAll(string req);
    logic [31:0] rd;
    check({req, " R7 rstOut"}, rstOut, {model[1], model[0]});
    check({req, " R6 clkEn"}, clkEn, expClkEn());
    for (int w = 0; w < 4; w++) begin
      busRead(base[w], rd);
      check({req, " R8 base read"}, 64'(rd), 64'(model[w]));
      busRead(base[w] + 4, rd);
      check({req, " R8 alias read"}, 64'(rd), 64'(model[w]));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: power-on state
    model[0] = '1; model[1] = '1; model[2] = 32'hFFFF_BFFF; model[3] = '1;
    check("R1 clkEn all stopped", clkEn, 64'h0);
    check("R1 rstOut all held", rstOut, '1);
    busRead('h080, rd);
    check("R1 clock low word", 64'(rd), 64'hFFFF_BFFF);
    verifyAll("R1");

    // R3: clear everything through the clear aliases
    for (int w = 0; w < 4; w++) begin
      busWrite(base[w] + 4, '1);
      model[w] = '0;
    end
    verifyAll("R3 clear all");
    check("R6 cleared stop bits", clkEn, ~(64'h1 << 14));

    // R5/R2/R3: walking one bit across all 64 indices of both word pairs
    for (int w = 0; w < 4; w++) begin
      for (int b = 0; b < 32; b++) begin
        int idx;
        idx = (w % 2) * 32 + b;
        busWrite(base[w], 32'h1 << b);
        model[w] = model[w] | (32'h1 << b);
        if (w < 2) check("R5 reset index set", 64'(rstOut[idx]), 64'(1'b1));
        else check("R5 clock index set", 64'(clkEn[idx]), 64'((idx == 14) ? 1'b1 : 1'b0));
        busRead(base[w], rd);
        check("R2 single bit set readback", 64'(rd), 64'(model[w]));
        busWrite(base[w] + 4, 32'h1 << b);
        model[w] = model[w] & ~(32'h1 << b);
        if (w < 2) check("R5 reset index clear", 64'(rstOut[idx]), 64'(1'b0));
        else check("R5 clock index clear", 64'(clkEn[idx]), 64'((idx == 14) ? 1'b0 : 1'b1));
      end
    end

    // R2/R3/R4: mixed patterns, alternating set and clear, with zero writes
    for (int k = 0; k < 24; k++) begin
      int w;
      logic [31:0] d;
      w = k % 4;
      d = (32'h9E37_79B9 * 32'(k + 3)) ^ (32'(k) << 7);
      if ((k / 4) % 2 == 0) begin
        busWrite(base[w], d);
        model[w] = model[w] | d;
      end else begin
        busWrite(base[w] + 4, d);
        model[w] = model[w] & ~d;
      end
      verifyAll((k / 4) % 2 == 0 ? "R2 pattern set" : "R3 pattern clear");
      busWrite(base[w], 32'h0);
      busWrite(base[w] + 4, 32'h0);
      verifyAll("R4 zero write");
    end

    // R9: unmapped and unaligned addresses
    foreach (base[i]) ;
    begin
      int unm [8] = '{'h000, 'h048, 'h04C, 'h060, 'h088, 'h098, 'h041, 'hFFC};
      for (int u = 0; u < 8; u++) begin
        busWrite(unm[u], '1);
        busRead(unm[u], rd);
        check("R9 unmapped read zero", 64'(rd), 64'h0);
      end
      verifyAll("R9 unmapped write ignored");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule